// File: doc/BRIEF.md
# Register Window Occupancy Counter Unit

This unit keeps the bookkeeping state of a windowed register file: the number of windows that may still be saved into, the number that may be restored from, the number that belong to another context, the number of clean windows, a six-bit window-state word that selects trap handlers, and the current window pointer. It performs one window operation per cycle. A save or a restore moves the pointer and rebalances the counters. A flush checks that every window has been spilled. The saved and restored operations come from trap handlers that have finished spilling or filling a window. When an operation cannot go ahead, the unit leaves all of its state alone and raises a trap carrying a trap-type code built from the window-state word.

The pointer is held internally in hardware order. Software sees it reversed, as the window count minus one minus the internal value. Software writes of the pointer are reduced modulo the window count. Write operations also load each counter and the window-state word, so that a trap handler or a context switch can set them up.

Top module: `win_occ_unit`

## Requirements
- R1: A save (op code 1) with the save counter at 0 raises a spill trap whose code follows R5, and nothing else changes.
- R2: A save with a nonzero save counter and the clean counter equal to the restore counter raises a clean-window trap with code 0x024.
- R3: Any other save decrements the save counter and increments the restore counter. It decrements the internal pointer modulo the window count, so the visible window number goes up by one modulo the count.
- R4: A restore (op code 2) with the restore counter at 0 raises a fill trap whose code follows R5. Otherwise it increments the save counter, decrements the restore counter and increments the internal pointer modulo the window count.
- R5: A spill code is 0x080 and a fill code is 0x0C0, each ORed with a selector. When the other-context counter is nonzero, the selector is 0x020 ORed with window-state bits 5:3 shifted left by 2. Otherwise it is window-state bits 2:0 shifted left by 2.
- R6: A flush (op code 3) raises a spill trap (R5) unless the save counter equals the window count minus 2. In that case nothing changes.
- R7: A saved operation (op code 4) increments the save counter. It then decrements the other-context counter if that is nonzero, and otherwise decrements the restore counter. Counters wrap at their width.
- R8: A restored operation (op code 5) increments the restore counter. It increments the clean counter only while that is below the window count minus 1. It then decrements the other-context counter if that is nonzero, and otherwise decrements the save counter.
- R9: The visible window number is always the window count minus 1 minus the internal pointer. A pointer write (op code 6) of value v makes the visible number v modulo the window count.
- R10: A trap leaves every counter, the window-state word and the pointer unchanged. The trap flag is high for exactly the one cycle after the operation that caused it.
- R11: Op codes 7, 8, 9, 10 and 11 load the save, restore, other-context and clean counters from the low counter-width bits of the data, and the window-state word from data bits 5:0. With op_valid low, or with an undefined op code, nothing changes.
- R12: After reset all counters and the window-state word are 0, the visible window number is the window count minus 1, and the trap flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select (codes in R1 to R11) |
| op_data | input | DW | Write data for pointer, counter and window-state writes |
| cansave_o | output | CW | Save counter |
| canrestore_o | output | CW | Restore counter |
| otherwin_o | output | CW | Other-context counter |
| cleanwin_o | output | CW | Clean window counter |
| wstate_o | output | 6 | Window-state word |
| cwp_sw_o | output | CW | Software-visible window number |
| trap_o | output | 1 | Trap raised by the previous operation |
| trap_type_o | output | TTW | Trap-type code, valid while trap_o is high |

## Verification
Every result of this block is registered. The counters, the window-state word, the visible window number and the trap flag with its code all appear after the first rising edge that samples the operation. The one exception is the end of reset: its synchronizer adds two edges before operations are accepted. The bench applies each operation on a falling edge and compares all outputs on the next falling edge, a full cycle later. One more cycle after each operation, it checks that the trap flag has dropped again. The sweep loads every combination of save, restore and clean counters for a five-window setup, with the other-context counter both zero and nonzero. It then applies each window operation and predicts the outcome arithmetically.

// File: rtl/woc_pkg.sv
package woc_pkg;

  typedef enum logic [3:0] {
    OP_NONE        = 4'd0,
    OP_SAVE        = 4'd1,
    OP_RESTORE     = 4'd2,
    OP_FLUSH       = 4'd3,
    OP_SAVED       = 4'd4,
    OP_RESTORED    = 4'd5,
    OP_WR_PTR      = 4'd6,
    OP_WR_SAVE     = 4'd7,
    OP_WR_RESTORE  = 4'd8,
    OP_WR_OTHER    = 4'd9,
    OP_WR_CLEAN    = 4'd10,
    OP_WR_WSTATE   = 4'd11
  } woc_op_e;

  typedef enum logic [1:0] {
    TK_NONE  = 2'd0,
    TK_SPILL = 2'd1,
    TK_FILL  = 2'd2,
    TK_CLEAN = 2'd3
  } trap_kind_e;

  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_DEC  = 2'd1,
    PTR_INC  = 2'd2,
    PTR_LOAD = 2'd3
  } ptr_op_e;

endpackage

// File: rtl/woc_decide.sv
module woc_decide
  import woc_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [CW-1:0] wr_val,
  input  logic [CW-1:0] cansave,
  input  logic [CW-1:0] canrestore,
  input  logic [CW-1:0] otherwin,
  input  logic [CW-1:0] cleanwin,
  output trap_kind_e    trap_kind,
  output logic          ctr_we,
  output logic [CW-1:0] cansave_nx,
  output logic [CW-1:0] canrestore_nx,
  output logic [CW-1:0] otherwin_nx,
  output logic [CW-1:0] cleanwin_nx,
  output logic          wstate_we,
  output ptr_op_e       ptr_op
);

  localparam logic [CW-1:0] ONE       = CW'(1);
  localparam logic [CW-1:0] FLUSH_LVL = CW'(NWIN - 2);
  localparam logic [CW-1:0] CLEAN_MAX = CW'(NWIN - 1);

  woc_op_e op_e;
  logic    other_busy;

  assign op_e       = woc_op_e'(op_code);
  assign other_busy = (otherwin != '0);

  always_comb begin
    trap_kind     = TK_NONE;
    ctr_we        = 1'b0;
    wstate_we     = 1'b0;
    ptr_op        = PTR_HOLD;
    cansave_nx    = cansave;
    canrestore_nx = canrestore;
    otherwin_nx   = otherwin;
    cleanwin_nx   = cleanwin;
    if (op_valid) begin
      case (op_e)
        OP_SAVE: begin
          if (cansave == '0) begin
            trap_kind = TK_SPILL;
          end else if (cleanwin == canrestore) begin
            trap_kind = TK_CLEAN;
          end else begin
            ctr_we        = 1'b1;
            cansave_nx    = cansave - ONE;
            canrestore_nx = canrestore + ONE;
            ptr_op        = PTR_DEC;
          end
        end
        OP_RESTORE: begin
          if (canrestore == '0) begin
            trap_kind = TK_FILL;
          end else begin
            ctr_we        = 1'b1;
            cansave_nx    = cansave + ONE;
            canrestore_nx = canrestore - ONE;
            ptr_op        = PTR_INC;
          end
        end
        OP_FLUSH: begin
          if (cansave != FLUSH_LVL) trap_kind = TK_SPILL;
        end
        OP_SAVED: begin
          ctr_we     = 1'b1;
          cansave_nx = cansave + ONE;
          if (other_busy) otherwin_nx   = otherwin - ONE;
          else            canrestore_nx = canrestore - ONE;
        end
        OP_RESTORED: begin
          ctr_we        = 1'b1;
          canrestore_nx = canrestore + ONE;
          if (cleanwin < CLEAN_MAX) cleanwin_nx = cleanwin + ONE;
          if (other_busy) otherwin_nx = otherwin - ONE;
          else            cansave_nx  = cansave - ONE;
        end
        OP_WR_PTR:     ptr_op = PTR_LOAD;
        OP_WR_SAVE:    begin ctr_we = 1'b1; cansave_nx    = wr_val; end
        OP_WR_RESTORE: begin ctr_we = 1'b1; canrestore_nx = wr_val; end
        OP_WR_OTHER:   begin ctr_we = 1'b1; otherwin_nx   = wr_val; end
        OP_WR_CLEAN:   begin ctr_we = 1'b1; cleanwin_nx   = wr_val; end
        OP_WR_WSTATE:  wstate_we = 1'b1;
        default: ;
      endcase
    end
  end

  // R1: an empty save budget always ends in a spill
  assert_spill_when_empty_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    (op_valid && op_code == 4'd1 && cansave == '0) |-> (trap_kind == TK_SPILL && !ctr_we));

  // R10: no trap outcome ever requests a state update
  assert_trap_blocks_update_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    (trap_kind != TK_NONE) |-> (!ctr_we && !wstate_we && ptr_op == PTR_HOLD));

endmodule

// File: rtl/woc_trapcode.sv
module woc_trapcode
  import woc_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int WSF = 3,
  parameter int TTW = 9,
  parameter logic [TTW-1:0] SPILL_BASE = TTW'(9'h080),
  parameter logic [TTW-1:0] FILL_BASE  = TTW'(9'h0C0),
  parameter logic [TTW-1:0] CLEAN_TT   = TTW'(9'h024),
  parameter logic [TTW-1:0] OTHER_FLAG = TTW'(9'h020),
  localparam int CW = $clog2(NWIN),
  localparam int WSW = 2 * WSF
) (
  input  trap_kind_e     trap_kind,
  input  logic [CW-1:0]  otherwin,
  input  logic [WSW-1:0] wstate,
  output logic [TTW-1:0] code
);

  logic [TTW-1:0] sel_user;
  logic [TTW-1:0] sel_other;
  logic [TTW-1:0] sel;

  assign sel_user  = TTW'(wstate[WSF-1:0]) << 2;
  assign sel_other = OTHER_FLAG | (TTW'(wstate[WSW-1:WSF]) << 2);
  assign sel       = (otherwin != '0) ? sel_other : sel_user;

  always_comb begin
    case (trap_kind)
      TK_SPILL: code = SPILL_BASE | sel;
      TK_FILL:  code = FILL_BASE | sel;
      TK_CLEAN: code = CLEAN_TT;
      default:  code = '0;
    endcase
  end

endmodule

// File: rtl/woc_pointer.sv
module woc_pointer
  import woc_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  ptr_op_e       ptr_op,
  input  logic [DW-1:0] wr_data,
  output logic [CW-1:0] cwp_sw
);

  localparam logic [CW-1:0] TOP = CW'(NWIN - 1);

  logic [CW-1:0] cwp_q;
  logic [CW-1:0] cwp_nx;
  logic          cwp_en;
  int            wr_mod;

  always_comb begin
    wr_mod = int'(wr_data) % NWIN;
    cwp_en = (ptr_op != PTR_HOLD);
    case (ptr_op)
      PTR_DEC:  cwp_nx = (cwp_q == '0) ? TOP : cwp_q - CW'(1);
      PTR_INC:  cwp_nx = (cwp_q == TOP) ? '0 : cwp_q + CW'(1);
      PTR_LOAD: cwp_nx = CW'(NWIN - 1 - wr_mod);
      default:  cwp_nx = cwp_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     cwp_q <= '0;
    else if (cwp_en) cwp_q <= cwp_nx;
  end

  assign cwp_sw = TOP - cwp_q;

  // R9: internal pointer never leaves the window range
  assert_ptr_in_range_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (int'(cwp_q) < NWIN));

  // R3: a successful save steps the internal pointer down with wrap
  assert_ptr_dec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (ptr_op == PTR_DEC) |=> (cwp_q == (($past(cwp_q) == '0) ? TOP : $past(cwp_q) - CW'(1))));

  // R4: a successful restore steps the internal pointer up with wrap
  assert_ptr_inc_wrap_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (ptr_op == PTR_INC) |=> (cwp_q == (($past(cwp_q) == TOP) ? '0 : $past(cwp_q) + CW'(1))));

endmodule

// File: rtl/woc_counters.sv
module woc_counters
  import woc_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int WSF = 3,
  localparam int CW = $clog2(NWIN),
  localparam int WSW = 2 * WSF
) (
  input  logic           clk,
  input  logic           rst_ns,
  input  logic           ctr_we,
  input  logic [CW-1:0]  cansave_nx,
  input  logic [CW-1:0]  canrestore_nx,
  input  logic [CW-1:0]  otherwin_nx,
  input  logic [CW-1:0]  cleanwin_nx,
  input  logic           wstate_we,
  input  logic [WSW-1:0] wstate_nx,
  output logic [CW-1:0]  cansave,
  output logic [CW-1:0]  canrestore,
  output logic [CW-1:0]  otherwin,
  output logic [CW-1:0]  cleanwin,
  output logic [WSW-1:0] wstate
);

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cansave    <= '0;
      canrestore <= '0;
      otherwin   <= '0;
      cleanwin   <= '0;
    end else if (ctr_we) begin
      cansave    <= cansave_nx;
      canrestore <= canrestore_nx;
      otherwin   <= otherwin_nx;
      cleanwin   <= cleanwin_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)        wstate <= '0;
    else if (wstate_we) wstate <= wstate_nx;
  end

  // R11: counters move only under their write enable
  assert_ctr_hold_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    !ctr_we |=> ($stable(cansave) && $stable(canrestore) && $stable(otherwin) && $stable(cleanwin)));

endmodule

// File: rtl/win_occ_unit.sv
module win_occ_unit
  import woc_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW = 8,
  parameter int WSF = 3,
  parameter int TTW = 9,
  parameter logic [TTW-1:0] SPILL_BASE = TTW'(9'h080),
  parameter logic [TTW-1:0] FILL_BASE  = TTW'(9'h0C0),
  parameter logic [TTW-1:0] CLEAN_TT   = TTW'(9'h024),
  parameter logic [TTW-1:0] OTHER_FLAG = TTW'(9'h020),
  localparam int CW = $clog2(NWIN),
  localparam int WSW = 2 * WSF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [3:0]     op_code,
  input  logic [DW-1:0]  op_data,
  output logic [CW-1:0]  cansave_o,
  output logic [CW-1:0]  canrestore_o,
  output logic [CW-1:0]  otherwin_o,
  output logic [CW-1:0]  cleanwin_o,
  output logic [WSW-1:0] wstate_o,
  output logic [CW-1:0]  cwp_sw_o,
  output logic           trap_o,
  output logic [TTW-1:0] trap_type_o
);

  logic [1:0]     rst_pipe;
  logic           rst_ns;
  trap_kind_e     trap_kind;
  logic           ctr_we;
  logic           wstate_we;
  ptr_op_e        ptr_op;
  logic [CW-1:0]  cs_nx, cr_nx, ow_nx, cw_nx;
  logic [TTW-1:0] code_nx;
  logic           trap_nx;
  logic           trap_q;
  logic [TTW-1:0] type_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  woc_decide #(.NWIN(NWIN)) u_decide (
    .clk(clk), .rst_ns(rst_ns),
    .op_valid(op_valid), .op_code(op_code), .wr_val(op_data[CW-1:0]),
    .cansave(cansave_o), .canrestore(canrestore_o),
    .otherwin(otherwin_o), .cleanwin(cleanwin_o),
    .trap_kind(trap_kind), .ctr_we(ctr_we),
    .cansave_nx(cs_nx), .canrestore_nx(cr_nx),
    .otherwin_nx(ow_nx), .cleanwin_nx(cw_nx),
    .wstate_we(wstate_we), .ptr_op(ptr_op)
  );

  woc_counters #(.NWIN(NWIN), .WSF(WSF)) u_counters (
    .clk(clk), .rst_ns(rst_ns),
    .ctr_we(ctr_we),
    .cansave_nx(cs_nx), .canrestore_nx(cr_nx),
    .otherwin_nx(ow_nx), .cleanwin_nx(cw_nx),
    .wstate_we(wstate_we), .wstate_nx(op_data[WSW-1:0]),
    .cansave(cansave_o), .canrestore(canrestore_o),
    .otherwin(otherwin_o), .cleanwin(cleanwin_o),
    .wstate(wstate_o)
  );

  woc_pointer #(.NWIN(NWIN), .DW(DW)) u_pointer (
    .clk(clk), .rst_ns(rst_ns),
    .ptr_op(ptr_op), .wr_data(op_data),
    .cwp_sw(cwp_sw_o)
  );

  woc_trapcode #(
    .NWIN(NWIN), .WSF(WSF), .TTW(TTW),
    .SPILL_BASE(SPILL_BASE), .FILL_BASE(FILL_BASE),
    .CLEAN_TT(CLEAN_TT), .OTHER_FLAG(OTHER_FLAG)
  ) u_trapcode (
    .trap_kind(trap_kind), .otherwin(otherwin_o),
    .wstate(wstate_o), .code(code_nx)
  );

  assign trap_nx = (trap_kind != TK_NONE);

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) trap_q <= 1'b0;
    else         trap_q <= trap_nx;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)      type_q <= '0;
    else if (trap_nx) type_q <= code_nx;
  end

  assign trap_o      = trap_q;
  assign trap_type_o = type_q;

  // R10: a trapping operation freezes every visible piece of state
  assert_trap_freezes_state_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    trap_nx |=> ($stable(cansave_o) && $stable(canrestore_o) && $stable(otherwin_o)
                 && $stable(cleanwin_o) && $stable(wstate_o) && $stable(cwp_sw_o) && trap_o));

  // R3: a successful save moves one window from the save budget to the restore budget
  assert_save_rebalance_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (op_valid && op_code == 4'd1 && !trap_nx)
      |=> (cansave_o == $past(cansave_o) - CW'(1) && canrestore_o == $past(canrestore_o) + CW'(1)));

  // R8: the clean counter never climbs past the top window on a restored operation
  assert_clean_saturates_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (op_valid && op_code == 4'd5 && cleanwin_o == CW'(NWIN - 1)) |=> (cleanwin_o == CW'(NWIN - 1)));

  // R10: the trap flag is a single-cycle pulse unless a new trap follows
  assert_trap_pulse_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    !trap_nx |=> !trap_o);

endmodule

// File: tb/win_occ_unit_bench.sv
`timescale 1ns/1ps
module win_occ_unit_bench;

  localparam int N = 5;
  localparam int CW = 3;
  localparam int MSK = 7;

  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] op_code;
  logic [7:0] op_data;
  logic [CW-1:0] cansave_o, canrestore_o, otherwin_o, cleanwin_o, cwp_sw_o;
  logic [5:0] wstate_o;
  logic       trap_o;
  logic [8:0] trap_type_o;

  int vectors = 0;
  int fails = 0;

  win_occ_unit #(.NWIN(N)) u_win_occ_unit (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
    .cansave_o(cansave_o), .canrestore_o(canrestore_o),
    .otherwin_o(otherwin_o), .cleanwin_o(cleanwin_o),
    .wstate_o(wstate_o), .cwp_sw_o(cwp_sw_o),
    .trap_o(trap_o), .trap_type_o(trap_type_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // starts and ends at a falling edge; outputs reflect the op on return
  task automatic do_op(input int code, input int data);
    op_valid = 1'b1;
    op_code  = 4'(code);
    op_data  = 8'(data);
    @(negedge clk);
    op_valid = 1'b0;
    op_code  = 4'd0;
    op_data  = 8'd0;
  endtask

  task automatic load(input int cs, input int cr, input int ow, input int cw,
                      input int ws, input int vis);
    do_op(7, cs);
    do_op(8, cr);
    do_op(9, ow);
    do_op(10, cw);
    do_op(11, ws);
    do_op(6, vis);
  endtask

  task automatic check_state(input string req, input int cs, input int cr, input int ow,
                             input int cw, input int ws, input int vis);
    chk({req, " cansave"}, int'(cansave_o), cs);
    chk({req, " canrestore"}, int'(canrestore_o), cr);
    chk({req, " otherwin"}, int'(otherwin_o), ow);
    chk({req, " cleanwin"}, int'(cleanwin_o), cw);
    chk({req, " wstate"}, int'(wstate_o), ws);
    chk({req, " window"}, int'(cwp_sw_o), vis);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    op_valid = 1'b0;
    op_code  = 4'd0;
    op_data  = 8'd0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12: reset state
    check_state("R12", 0, 0, 0, 0, 0, N - 1);
    chk("R12 trap", int'(trap_o), 0);

    // R11: loads, idle cycles and undefined codes
    load(3, 2, 1, 4, 45, 2);
    check_state("R11 load", 3, 2, 1, 4, 45, 2);
    op_code = 4'd1;
    op_valid = 1'b0;
    @(negedge clk);
    op_code = 4'd0;
    check_state("R11 idle", 3, 2, 1, 4, 45, 2);
    do_op(15, 0);
    check_state("R11 undefined", 3, 2, 1, 4, 45, 2);
    chk("R11 trap", int'(trap_o), 0);

    // R9: pointer writes reduce modulo the window count
    for (int v = 0; v < 24; v++) begin
      do_op(6, v);
      chk("R9 write", int'(cwp_sw_o), v % N);
    end

    // R1..R8, R10: sweep of every window operation
    for (int cs = 0; cs < N; cs++)
      for (int cr = 0; cr < N; cr++)
        for (int cw = 0; cw < N; cw++)
          for (int oi = 0; oi < 2; oi++)
            for (int k = 0; k < 5; k++) begin
              int ow, ws, vis, p, sel, tt;
              int e_cs, e_cr, e_ow, e_cw;
              bit trap;
              string req;
              ow  = oi * 3;
              ws  = (cs * 13 + cr * 7 + cw * 3 + oi * 29 + k) & 63;
              vis = (cs + 2 * cr + cw + k) % N;
              p   = N - 1 - vis;
              sel = (ow != 0) ? (32 | (((ws >> 3) & 7) << 2)) : ((ws & 7) << 2);
              e_cs = cs; e_cr = cr; e_ow = ow; e_cw = cw;
              trap = 1'b0; tt = 0;
              case (k)
                0: begin
                  if (cs == 0) begin
                    req = "R1"; trap = 1'b1; tt = 128 | sel;
                  end else if (cw == cr) begin
                    req = "R2"; trap = 1'b1; tt = 36;
                  end else begin
                    req = "R3"; e_cs = cs - 1; e_cr = (cr + 1) & MSK; p = (p + N - 1) % N;
                  end
                end
                1: begin
                  req = "R4";
                  if (cr == 0) begin
                    trap = 1'b1; tt = 192 | sel;
                  end else begin
                    e_cs = (cs + 1) & MSK; e_cr = cr - 1; p = (p + 1) % N;
                  end
                end
                2: begin
                  req = "R6";
                  if (cs != N - 2) begin
                    trap = 1'b1; tt = 128 | sel;
                  end
                end
                3: begin
                  req = "R7";
                  e_cs = (cs + 1) & MSK;
                  if (ow != 0) e_ow = ow - 1;
                  else         e_cr = (cr - 1) & MSK;
                end
                default: begin
                  req = "R8";
                  e_cr = (cr + 1) & MSK;
                  if (cw < N - 1) e_cw = cw + 1;
                  if (ow != 0) e_ow = ow - 1;
                  else         e_cs = (cs - 1) & MSK;
                end
              endcase
              load(cs, cr, ow, cw, ws, vis);
              do_op(k + 1, 0);
              check_state(req, e_cs, e_cr, e_ow, e_cw, ws, N - 1 - p);
              chk({req, " trap flag"}, int'(trap_o), int'(trap));
              if (trap) begin
                chk({req, " R5 trap code"}, int'(trap_type_o), tt);
                @(negedge clk);
                chk("R10 trap pulse ends", int'(trap_o), 0);
                check_state("R10 frozen", cs, cr, ow, cw, ws, vis);
              end
            end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule